// File: doc/BRIEF.md
# Control-Flow Target Unit

This block decides where a 32-bit RISC core fetches next and whether a control-transfer instruction leaves a return address behind. Each cycle it takes the current program counter, the instruction word and the two register operands already read for that instruction. From these it computes the next program counter. When the instruction is a call form, it also computes the link value and the index of the register that receives it.

Conditional branches compare the two operands for equality or inequality, or test the sign of the first operand. A branch offset counts instructions, not bytes. It is measured from the instruction after the branch. A direct jump keeps the top address bits of the following instruction and replaces the rest with its 26-bit field. Register jumps take their target from the first operand. Two call forms exist: one always links into register 31, and the other links into the register named in the instruction. Every result is registered, so it appears one clock after the inputs are presented.

Top module: `flow_target_unit`

## Requirements
- R1: While `rst` is high on a clock edge, all four outputs are cleared to zero on that edge.
- R2: Opcode 4 (instruction bits 31:26) branches when `rs_val` equals `rt_val`. The target is PC+4 plus the sign-extended 16-bit field (bits 15:0) shifted left by 2. Otherwise `next_pc` is PC+4.
- R3: Opcode 5 branches to the same form of target when `rs_val` differs from `rt_val`. Otherwise `next_pc` is PC+4.
- R4: Opcode 1 with bits 20:16 equal to 0 branches when bit 31 of `rs_val` is set, that is, when the operand is negative. Otherwise `next_pc` is PC+4.
- R5: Opcode 2 jumps to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}, and `link_we` stays low.
- R6: Opcode 3 jumps to the same target as R5. It raises `link_we`, with `link_idx` = 31 and `link_val` = PC+4.
- R7: Opcode 0 with function field (bits 5:0) equal to 8 sets `next_pc` to `rs_val` and keeps `link_we` low.
- R8: Opcode 0 with function field 9 sets `next_pc` to `rs_val`. It raises `link_we`, with `link_idx` taken from instruction bits 15:11 and `link_val` = PC+4.
- R9: Any other instruction sets `next_pc` to PC+4 and holds `link_we`, `link_idx` and `link_val` at zero. This covers ALU and memory opcodes, opcode 0 with any other function, and opcode 1 with bits 20:16 nonzero.
- R10: Results appear exactly one clock after the inputs are sampled. Inputs that change on every cycle give one result on every cycle.
- R11: Address arithmetic wraps modulo 2^32. A negative displacement gives a backward target, and PC+4 from 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 32 | Address of the current instruction |
| instr_in | input | 32 | Current instruction word |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| next_pc | output | 32 | Registered address of the next instruction |
| link_we | output | 1 | Registered request to write a return address |
| link_idx | output | 5 | Registered index of the register receiving the return address |
| link_val | output | 32 | Registered return address (PC+4) |

## Verification
The two functions that fall in the same cycle are the redirect and the link write. A call form must change `next_pc` and produce the return address and its register index on the same edge. The bench provokes this with the fixed-register call and with the register call naming register 7 and register 31. These are issued back to back among ordinary branches. For each result, the scoreboard compares the redirected target and all three link outputs together against an independently computed entry. A plain jump, a register jump and a non-control instruction are placed next to the calls, and the bench checks that none of them raises the link write.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int SEL_W = 5;

  localparam logic [OP_W-1:0]  OP_REG_FORM  = 6'd0;
  localparam logic [OP_W-1:0]  OP_SIGN_TEST = 6'd1;
  localparam logic [OP_W-1:0]  OP_GOTO      = 6'd2;
  localparam logic [OP_W-1:0]  OP_CALL      = 6'd3;
  localparam logic [OP_W-1:0]  OP_EQ_BR     = 6'd4;
  localparam logic [OP_W-1:0]  OP_NE_BR     = 6'd5;
  localparam logic [FN_W-1:0]  FN_REG_GOTO  = 6'd8;
  localparam logic [FN_W-1:0]  FN_REG_CALL  = 6'd9;
  localparam logic [SEL_W-1:0] SEL_NEG      = 5'd0;

  typedef enum logic [2:0] {
    FK_SEQ,
    FK_EQ,
    FK_NE,
    FK_NEG,
    FK_GOTO,
    FK_CALL,
    FK_RGOTO,
    FK_RCALL
  } flow_kind_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
#(
  parameter int IW    = 32,
  parameter int IDX_W = 5,
  parameter int DISP_W = 16,
  parameter int FIELD_W = 26
) (
  input  logic [IW-1:0]      instr,
  output flow_kind_e         kind,
  output logic [DISP_W-1:0]  disp,
  output logic [FIELD_W-1:0] region,
  output logic [IDX_W-1:0]   rd_sel
);
  localparam int OP_LO  = IW - OP_W;
  localparam int SEL_LO = OP_LO - 2 * IDX_W;
  localparam int RD_LO  = SEL_LO - IDX_W;

  logic [OP_W-1:0]  op;
  logic [FN_W-1:0]  fn;
  logic [IDX_W-1:0] sel;

  assign op     = instr[IW-1:OP_LO];
  assign fn     = instr[FN_W-1:0];
  assign sel    = instr[SEL_LO +: IDX_W];
  assign rd_sel = instr[RD_LO +: IDX_W];
  assign disp   = instr[DISP_W-1:0];
  assign region = instr[FIELD_W-1:0];

  always_comb begin
    kind = FK_SEQ;
    unique case (op)
      OP_EQ_BR:     kind = FK_EQ;
      OP_NE_BR:     kind = FK_NE;
      OP_GOTO:      kind = FK_GOTO;
      OP_CALL:      kind = FK_CALL;
      OP_SIGN_TEST: if (sel == SEL_NEG) kind = FK_NEG;
      OP_REG_FORM: begin
        if (fn == FN_REG_GOTO)      kind = FK_RGOTO;
        else if (fn == FN_REG_CALL) kind = FK_RCALL;
      end
      default:      kind = FK_SEQ;
    endcase
  end
endmodule

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_kind_e      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  logic same;
  assign same = (opa == opb);

  always_comb begin
    case (kind)
      FK_EQ:   taken = same;
      FK_NE:   taken = !same;
      FK_NEG:  taken = opa[XLEN-1];
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/flow_target.sv
module flow_target
  import flow_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IDX_W    = 5,
  parameter int DISP_W   = 16,
  parameter int FIELD_W  = 26,
  parameter int LINK_IDX = 31
) (
  input  logic [AW-1:0]      pc,
  input  flow_kind_e         kind,
  input  logic               taken,
  input  logic [DISP_W-1:0]  disp,
  input  logic [FIELD_W-1:0] region,
  input  logic [IDX_W-1:0]   rd_sel,
  input  logic [AW-1:0]      reg_tgt,
  output logic [AW-1:0]      nxt,
  output logic               lwe,
  output logic [IDX_W-1:0]   lidx,
  output logic [AW-1:0]      lval
);
  localparam int STEP   = 4;
  localparam int KEEP_W = AW - FIELD_W - 2;
  localparam int EXT_W  = AW - DISP_W - 2;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] br_pc;
  logic [AW-1:0] region_pc;

  assign seq_pc    = pc + AW'(STEP);
  assign br_pc     = seq_pc + {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign region_pc = {seq_pc[AW-1 -: KEEP_W], region, 2'b00};

  always_comb begin
    nxt  = seq_pc;
    lwe  = 1'b0;
    lidx = '0;
    lval = '0;
    case (kind)
      FK_EQ, FK_NE, FK_NEG: if (taken) nxt = br_pc;
      FK_GOTO:  nxt = region_pc;
      FK_CALL: begin
        nxt  = region_pc;
        lwe  = 1'b1;
        lidx = IDX_W'(LINK_IDX);
        lval = seq_pc;
      end
      FK_RGOTO: nxt = reg_tgt;
      FK_RCALL: begin
        nxt  = reg_tgt;
        lwe  = 1'b1;
        lidx = rd_sel;
        lval = seq_pc;
      end
      default:  nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/flow_target_unit.sv
module flow_target_unit
  import flow_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    instr_in,
  input  logic [AW-1:0]    rs_val,
  input  logic [AW-1:0]    rt_val,
  output logic [AW-1:0]    next_pc,
  output logic             link_we,
  output logic [IDX_W-1:0] link_idx,
  output logic [AW-1:0]    link_val
);
  localparam int DISP_W  = 16;
  localparam int FIELD_W = 26;

  flow_kind_e         kind;
  logic [DISP_W-1:0]  disp;
  logic [FIELD_W-1:0] region;
  logic [IDX_W-1:0]   rd_sel;
  logic               taken;
  logic [AW-1:0]      nxt_c;
  logic               lwe_c;
  logic [IDX_W-1:0]   lidx_c;
  logic [AW-1:0]      lval_c;

  flow_decode #(.IW(AW), .IDX_W(IDX_W), .DISP_W(DISP_W), .FIELD_W(FIELD_W)) u_dec (
    .instr(instr_in), .kind(kind), .disp(disp), .region(region), .rd_sel(rd_sel)
  );

  flow_cond #(.XLEN(AW)) u_cond (
    .kind(kind), .opa(rs_val), .opb(rt_val), .taken(taken)
  );

  flow_target #(.AW(AW), .IDX_W(IDX_W), .DISP_W(DISP_W), .FIELD_W(FIELD_W),
                .LINK_IDX(LINK_IDX)) u_tgt (
    .pc(pc_in), .kind(kind), .taken(taken), .disp(disp), .region(region),
    .rd_sel(rd_sel), .reg_tgt(rs_val), .nxt(nxt_c), .lwe(lwe_c),
    .lidx(lidx_c), .lval(lval_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc  <= '0;
      link_we  <= 1'b0;
      link_idx <= '0;
      link_val <= '0;
    end else begin
      next_pc  <= nxt_c;
      link_we  <= lwe_c;
      link_idx <= lidx_c;
      link_val <= lval_c;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |->
    (next_pc == '0 && !link_we && link_idx == '0 && link_val == '0));

  // R6
  call_link_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_in[AW-1 -: OP_W]) == OP_CALL) |->
    (link_we && link_idx == IDX_W'(LINK_IDX) && next_pc[AW-1 -: 4] == link_val[AW-1 -: 4]
     && next_pc[1:0] == 2'b00));

  // R7
  reg_goto_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_in[AW-1 -: OP_W]) == OP_REG_FORM
     && $past(instr_in[5:0]) == FN_REG_GOTO) |->
    (next_pc == $past(rs_val) && !link_we));

  // R2
  eq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_in[AW-1 -: OP_W]) == OP_EQ_BR
     && $past(rs_val) != $past(rt_val)) |->
    (next_pc == $past(pc_in) + AW'(4)));

  // R9
  plain_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_in[AW-1 -: OP_W]) > OP_NE_BR) |->
    (next_pc == $past(pc_in) + AW'(4) && !link_we && link_val == '0));

  // R8
  rcall_link_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_in[AW-1 -: OP_W]) == OP_REG_FORM
     && $past(instr_in[5:0]) == FN_REG_CALL) |->
    (link_we && link_idx == $past(instr_in[15:11]) && link_val == $past(pc_in) + AW'(4)));
endmodule

// File: tb/tb_flow_target_unit.sv
module tb_flow_target_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_in = '0, instr_in = '0, rs_val = '0, rt_val = '0;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] npc;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] val;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flow_target_unit dut (
    .clk(clk), .rst(rst), .pc_in(pc_in), .instr_in(instr_in), .rs_val(rs_val),
    .rt_val(rt_val), .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val)
  );

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rd,
                                        input logic [5:0] fn);
    return {6'd0, rs, 5'd0, rd, 5'd0, fn};
  endfunction

  function automatic exp_t model(input logic [31:0] pc, input logic [31:0] ins,
                                 input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [31:0] nx;
    logic [31:0] off;
    nx    = pc + 32'd4;
    off   = {{14{ins[15]}}, ins[15:0], 2'b00};
    e.npc = nx; e.we = 1'b0; e.idx = 5'd0; e.val = 32'd0;
    case (ins[31:26])
      6'd4: if (a == b) e.npc = nx + off;
      6'd5: if (a != b) e.npc = nx + off;
      6'd1: if (ins[20:16] == 5'd0 && $signed(a) < 0) e.npc = nx + off;
      6'd2: e.npc = {nx[31:28], ins[25:0], 2'b00};
      6'd3: begin e.npc = {nx[31:28], ins[25:0], 2'b00}; e.we = 1'b1; e.idx = 5'd31; e.val = nx; end
      6'd0: begin
        if (ins[5:0] == 6'd8) e.npc = a;
        else if (ins[5:0] == 6'd9) begin e.npc = a; e.we = 1'b1; e.idx = ins[15:11]; e.val = nx; end
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    pc_in = pc; instr_in = ins; rs_val = a; rt_val = b;
    e     = model(pc, ins, a, b);
    e.due = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (next_pc !== e.npc || link_we !== e.we || link_idx !== e.idx || link_val !== e.val) begin
        errors++;
        $display("FAIL %s: got npc=%h we=%0d idx=%0d val=%h exp npc=%h we=%0d idx=%0d val=%h",
                 e.tag, next_pc, link_we, link_idx, link_val, e.npc, e.we, e.idx, e.val);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    pc_in = 32'h1234_5678; instr_in = {6'd3, 26'h3FF_FFFF}; rs_val = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs clear under reset even with a call instruction applied
    checks++;
    if (next_pc !== 0 || link_we !== 0 || link_idx !== 0 || link_val !== 0) begin
      errors++;
      $display("FAIL R1: got npc=%h we=%0d idx=%0d val=%h exp all zero",
               next_pc, link_we, link_idx, link_val);
    end
    rst = 1'b0;

    // back-to-back stream, one result per cycle (R10)
    issue(32'h0000_1000, enc_i(6'd4, 5'd1, 5'd2, 16'h0010), 32'd7, 32'd7, "R2 eq taken fwd");
    issue(32'h0000_1000, enc_i(6'd4, 5'd1, 5'd2, 16'h0010), 32'd7, 32'd8, "R2 eq fall");
    issue(32'h0000_2000, enc_i(6'd4, 5'd1, 5'd2, 16'hFFFE), 32'd3, 32'd3, "R11 eq backward");
    issue(32'h0000_3000, enc_i(6'd5, 5'd1, 5'd2, 16'h0004), 32'd1, 32'd2, "R3 ne taken");
    issue(32'h0000_3000, enc_i(6'd5, 5'd1, 5'd2, 16'h0004), 32'd9, 32'd9, "R3 ne fall");
    issue(32'h0000_4000, enc_i(6'd1, 5'd1, 5'd0, 16'h8000), 32'h8000_0000, 32'd0, "R4 neg taken");
    issue(32'h0000_4000, enc_i(6'd1, 5'd1, 5'd0, 16'h0020), 32'd0, 32'd0, "R4 zero fall");
    issue(32'h0000_4000, enc_i(6'd1, 5'd1, 5'd1, 16'h0020), 32'hFFFF_FFFF, 32'd0, "R9 sign-test other sel");
    issue(32'hA000_0100, {6'd2, 26'h123_4567}, 32'd0, 32'd0, "R5 goto");
    issue(32'hA000_0100, {6'd3, 26'h000_0040}, 32'd0, 32'd0, "R6 call");
    issue(32'h0000_5000, enc_r(5'd4, 5'd0, 6'd8), 32'h0040_0000, 32'd0, "R7 reg goto");
    issue(32'h0000_6000, enc_r(5'd4, 5'd7, 6'd9), 32'h0000_8888, 32'd0, "R8 reg call rd7");
    issue(32'h0000_6004, enc_r(5'd4, 5'd31, 6'd9), 32'h0000_9990, 32'd0, "R8 reg call rd31");
    issue(32'h0000_7000, enc_r(5'd4, 5'd3, 6'd32), 32'h0000_1111, 32'd5, "R9 alu op");
    issue(32'h0000_7004, enc_i(6'd35, 5'd4, 5'd5, 16'h0018), 32'h0000_1111, 32'd0, "R9 load op");
    issue(32'hFFFF_FFFC, enc_i(6'd8, 5'd0, 5'd1, 16'h0001), 32'd0, 32'd0, "R11 seq wrap");
    issue(32'h0000_0000, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFE), 32'd0, 32'd0, "R11 branch wrap");
    issue(32'hF000_0000, {6'd3, 26'h3FF_FFFF}, 32'd0, 32'd0, "R6 call high region");
    issue(32'h0000_0008, enc_i(6'd2, 5'd0, 5'd0, 16'h0000), 32'd0, 32'd0, "R5 goto zero");

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: every issued item must have produced its result on its due cycle
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: got %0d results pending exp 0", sb.size());
    end
    finish_run();
  end
endmodule